// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block keeps the machine-level trap state of a small 32-bit hart: the exception program counter, the trap vector base, the cause, the trap value, and the two interrupt-enable bits of the status word (current enable and previous enable). The pipeline raises a trap request with a cause number, an interrupt flag, the trapping PC and the raw instruction word. The block answers in the same cycle with a redirect to the handler address. A return request gets a redirect back to the saved PC in the same way. The trap state changes on the next clock edge.

Faulting data addresses are posted on a separate strobe and held until the next trap uses them. A 12-bit CSR address/data port reads and writes the registers at their conventional machine CSR numbers. The port also serves four read-only identity words.

Whether compressed instructions exist is taken from bit 2 of the ISA-identity parameter. It decides how the saved PC is aligned on return.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, mstatus, mtvec, mepc, mcause and mtval read 0, and the held fault address is 0.
- R2: The CSR port decodes these addresses: mstatus 0x300 (MIE is bit 3, MPIE is bit 7, other bits read 0), misa 0x301, mtvec 0x305, mepc 0x341, mcause 0x342, mtval 0x343, vendor id 0xF11, architecture id 0xF12, implementation id 0xF13. Any other address reads 0. The four identity words always read the parameter value, 0x669, 0x80000003 and 1, and writes to them change nothing.
- R3: A read of mtvec returns the stored word with bit 1 forced to 0. All other bits are kept, including bit 0, which selects vectored mode.
- R4: On a taken trap, redirect_pc is mtvec with bits 1:0 cleared. When mtvec bit 0 is 1 and the trap is an interrupt, 4 × cause is added. Exceptions always go to the base.
- R5: A taken trap sets mepc to trap_pc. It sets mcause to the interrupt flag in bit 31 and the cause number in the low bits. MPIE takes the old MIE, and MIE becomes 0.
- R6: For an exception with cause 2, mtval gets the whole instruction word when its bits 1:0 are 11, and only its low 16 bits (zero-extended) otherwise. A taken interrupt writes mtval to 0.
- R7: For any other exception, mtval gets the held fault address. Any taken trap clears the held address. A fault strobe in the same cycle as a taken trap is lost.
- R8: On a taken return, redirect_pc is mepc with bit 0 cleared when compressed instructions are enabled, and with bits 1:0 cleared when they are not. MIE takes MPIE, and MPIE becomes 1. A write to mepc stores the full value unmasked.
- R9: An interrupt request is taken only when MIE is 1 and irq_pending AND irq_enable is non-zero. Otherwise it is ignored and changes no state. Exception requests are always taken.
- R10: When a trap and a return are taken in the same cycle, the trap wins. A CSR write in a cycle where a trap or return is taken is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request |
| trap_irq | input | 1 | Request is an interrupt |
| trap_cause | input | 5 | Cause number |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_insn | input | 32 | Raw instruction word |
| irq_pending | input | IRQ_N | Pending interrupt lines |
| irq_enable | input | IRQ_N | Per-line interrupt enables |
| mret_valid | input | 1 | Trap-return request |
| fault_valid | input | 1 | Strobe that holds fault_addr |
| fault_addr | input | 32 | Faulting data address |
| csr_wen | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| redirect_valid | output | 1 | A trap or return was taken this cycle |
| redirect_pc | output | 32 | Next PC for the taken event |

## Verification
A corrupted status bit or saved PC in this block stays hidden until a later event uses it. A wrong MIE shows up as a wrongly accepted or refused interrupt at the next interrupt request. A wrong MPIE or mepc shows up as a wrong redirect or status readback at the next return. The bench therefore reads every CSR back after each operation, so a bad register appears at the ports within one cycle. The held fault address has no readback, so it is checked through the next exception that consumes it.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned CAUSE_W = 5;
    localparam int unsigned CSR_AW  = 12;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [CAUSE_W-1:0] cause_t;
    typedef logic [CSR_AW-1:0]  csr_addr_t;

    localparam csr_addr_t CSR_MSTATUS = 12'h300;
    localparam csr_addr_t CSR_MISA    = 12'h301;
    localparam csr_addr_t CSR_MTVEC   = 12'h305;
    localparam csr_addr_t CSR_MEPC    = 12'h341;
    localparam csr_addr_t CSR_MCAUSE  = 12'h342;
    localparam csr_addr_t CSR_MTVAL   = 12'h343;
    localparam csr_addr_t CSR_VENDOR  = 12'hF11;
    localparam csr_addr_t CSR_ARCH    = 12'hF12;
    localparam csr_addr_t CSR_IMPL    = 12'hF13;

    localparam int unsigned ST_IE_BIT  = 3;
    localparam int unsigned ST_PIE_BIT = 7;

    localparam word_t VENDOR_ID = 32'h0000_0669;
    localparam word_t ARCH_ID   = 32'h8000_0003;
    localparam word_t IMPL_ID   = 32'h0000_0001;

    localparam cause_t CAUSE_ILLEGAL = 5'd2;

    typedef enum logic [1:0] {EV_NONE, EV_TRAP, EV_RETURN} event_e;

    typedef struct packed {
        logic   irq;
        cause_t cause;
        word_t  pc;
        word_t  insn;
    } trap_t;

    function automatic word_t pc_mask(input logic compressed);
        return compressed ? ~word_t'(1) : ~word_t'(3);
    endfunction

    function automatic word_t illegal_tval(input word_t insn);
        return (insn[1:0] == 2'b11) ? insn : {{(XLEN-16){1'b0}}, insn[15:0]};
    endfunction

    function automatic word_t make_cause(input logic irq, input cause_t cause);
        word_t c;
        c = word_t'(cause);
        c[XLEN-1] = irq;
        return c;
    endfunction

    function automatic word_t trap_target(input word_t tvec, input logic irq, input cause_t cause);
        word_t base;
        base = tvec & ~word_t'(3);
        if (tvec[0] && irq)
            base = base + (word_t'(cause) << 2);
        return base;
    endfunction

endpackage

// File: rtl/mtrap_ctl.sv
module mtrap_ctl
    import mtrap_pkg::*;
#(
    parameter int unsigned IRQ_N = 16
) (
    input  logic             trap_valid,
    input  logic             trap_irq,
    input  logic             mret_valid,
    input  logic             ie,
    input  logic [IRQ_N-1:0] irq_pending,
    input  logic [IRQ_N-1:0] irq_enable,
    output event_e           ev
);
    logic irq_ready;
    logic trap_take;

    assign irq_ready = ie && (|(irq_pending & irq_enable));
    assign trap_take = trap_valid && (!trap_irq || irq_ready);

    always_comb begin
        if (trap_take)       ev = EV_TRAP;
        else if (mret_valid) ev = EV_RETURN;
        else                 ev = EV_NONE;
    end
endmodule

// File: rtl/mtrap_fault_hold.sv
module mtrap_fault_hold
    import mtrap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fault_valid,
    input  word_t fault_addr,
    input  logic  consume,
    output word_t fault_q
);
    always_ff @(posedge clk) begin
        if (rst || consume) fault_q <= '0;
        else if (fault_valid) fault_q <= fault_addr;
    end
endmodule

// File: rtl/mtrap_regs.sv
module mtrap_regs
    import mtrap_pkg::*;
#(
    parameter word_t ISA_WORD = 32'h4000_1104
) (
    input  logic      clk,
    input  logic      rst,
    input  event_e    ev,
    input  trap_t     trap,
    input  word_t     fault_q,
    input  logic      csr_wen,
    input  csr_addr_t csr_addr,
    input  word_t     csr_wdata,
    output word_t     csr_rdata,
    output word_t     tvec_q,
    output word_t     epc_q,
    output word_t     cause_q,
    output word_t     tval_q,
    output logic      ie_q,
    output logic      pie_q
);
    word_t status_view;
    word_t tval_next;

    always_comb begin
        status_view = '0;
        status_view[ST_IE_BIT]  = ie_q;
        status_view[ST_PIE_BIT] = pie_q;
    end

    always_comb begin
        if (trap.irq)                       tval_next = '0;
        else if (trap.cause == CAUSE_ILLEGAL) tval_next = illegal_tval(trap.insn);
        else                                tval_next = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tvec_q  <= '0;
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
            ie_q    <= 1'b0;
            pie_q   <= 1'b0;
        end else begin
            case (ev)
                EV_TRAP: begin
                    epc_q   <= trap.pc;
                    cause_q <= make_cause(trap.irq, trap.cause);
                    tval_q  <= tval_next;
                    pie_q   <= ie_q;
                    ie_q    <= 1'b0;
                end
                EV_RETURN: begin
                    ie_q  <= pie_q;
                    pie_q <= 1'b1;
                end
                default: begin
                    if (csr_wen) begin
                        case (csr_addr)
                            CSR_MSTATUS: begin
                                ie_q  <= csr_wdata[ST_IE_BIT];
                                pie_q <= csr_wdata[ST_PIE_BIT];
                            end
                            CSR_MTVEC:  tvec_q  <= csr_wdata;
                            CSR_MEPC:   epc_q   <= csr_wdata;
                            CSR_MCAUSE: cause_q <= csr_wdata;
                            CSR_MTVAL:  tval_q  <= csr_wdata;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (csr_addr)
            CSR_MSTATUS: csr_rdata = status_view;
            CSR_MISA:    csr_rdata = ISA_WORD;
            CSR_MTVEC:   csr_rdata = tvec_q & ~word_t'(2);
            CSR_MEPC:    csr_rdata = epc_q;
            CSR_MCAUSE:  csr_rdata = cause_q;
            CSR_MTVAL:   csr_rdata = tval_q;
            CSR_VENDOR:  csr_rdata = VENDOR_ID;
            CSR_ARCH:    csr_rdata = ARCH_ID;
            CSR_IMPL:    csr_rdata = IMPL_ID;
            default:     csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int unsigned IRQ_N    = 16,
    parameter logic [31:0] ISA_WORD = 32'h4000_1104
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_valid,
    input  logic             trap_irq,
    input  logic [4:0]       trap_cause,
    input  logic [31:0]      trap_pc,
    input  logic [31:0]      trap_insn,
    input  logic [IRQ_N-1:0] irq_pending,
    input  logic [IRQ_N-1:0] irq_enable,
    input  logic             mret_valid,
    input  logic             fault_valid,
    input  logic [31:0]      fault_addr,
    input  logic             csr_wen,
    input  logic [11:0]      csr_addr,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    output logic             redirect_valid,
    output logic [31:0]      redirect_pc
);
    localparam logic COMPRESSED = ISA_WORD[2];

    event_e ev;
    trap_t  trap;
    word_t  fault_q;
    word_t  tvec_q, epc_q, cause_q, tval_q;
    logic   ie_q, pie_q;

    assign trap = '{irq: trap_irq, cause: trap_cause, pc: trap_pc, insn: trap_insn};

    mtrap_ctl #(.IRQ_N(IRQ_N)) u_ctl (
        .trap_valid (trap_valid),
        .trap_irq   (trap_irq),
        .mret_valid (mret_valid),
        .ie         (ie_q),
        .irq_pending(irq_pending),
        .irq_enable (irq_enable),
        .ev         (ev)
    );

    mtrap_fault_hold u_fault (
        .clk        (clk),
        .rst        (rst),
        .fault_valid(fault_valid),
        .fault_addr (fault_addr),
        .consume    (ev == EV_TRAP),
        .fault_q    (fault_q)
    );

    mtrap_regs #(.ISA_WORD(ISA_WORD)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .trap     (trap),
        .fault_q  (fault_q),
        .csr_wen  (csr_wen),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .tvec_q   (tvec_q),
        .epc_q    (epc_q),
        .cause_q  (cause_q),
        .tval_q   (tval_q),
        .ie_q     (ie_q),
        .pie_q    (pie_q)
    );

    assign redirect_valid = (ev != EV_NONE);
    assign redirect_pc    = (ev == EV_TRAP) ? trap_target(tvec_q, trap_irq, trap_cause)
                                            : (epc_q & pc_mask(COMPRESSED));
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk
    import mtrap_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input event_e      ev,
    input logic        trap_irq,
    input logic [4:0]  trap_cause,
    input logic [31:0] trap_pc,
    input logic [11:0] csr_addr,
    input logic [31:0] csr_rdata,
    input logic        ie_q,
    input logic        pie_q,
    input logic [31:0] epc_q,
    input logic [31:0] cause_q,
    input logic [31:0] fault_q
);
    // R5
    trap_ie_stack_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_TRAP |=> !ie_q && pie_q == $past(ie_q));
    // R5
    trap_epc_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_TRAP |=> epc_q == $past(trap_pc) && cause_q[31] == $past(trap_irq)
                          && cause_q[4:0] == $past(trap_cause));
    // R8
    ret_ie_restore_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_RETURN |=> pie_q && ie_q == $past(pie_q));
    // R7
    fault_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        ev == EV_TRAP |=> fault_q == '0);
    // R3
    tvec_bit1_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_addr == CSR_MTVEC |-> !csr_rdata[1]);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !ie_q && !pie_q && epc_q == '0 && fault_q == '0);
endmodule

bind mtrap_unit mtrap_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .trap_irq  (trap_irq),
    .trap_cause(trap_cause),
    .trap_pc   (trap_pc),
    .csr_addr  (csr_addr),
    .csr_rdata (csr_rdata),
    .ie_q      (ie_q),
    .pie_q     (pie_q),
    .epc_q     (epc_q),
    .cause_q   (cause_q),
    .fault_q   (fault_q)
);

// File: tb/mtrap_unit_tb.sv
`timescale 1ns/100ps
module mtrap_unit_tb;
    localparam int IRQ_N = 16;
    localparam logic [31:0] ISA_C  = 32'h4000_1104;
    localparam logic [31:0] ISA_NC = 32'h4000_1100;

    logic clk = 1'b0, rst = 1'b1;
    logic trap_valid = 0, trap_irq = 0, mret_valid = 0, fault_valid = 0, csr_wen = 0;
    logic [4:0]  trap_cause = '0;
    logic [31:0] trap_pc = '0, trap_insn = '0, fault_addr = '0, csr_wdata = '0;
    logic [11:0] csr_addr = '0;
    logic [IRQ_N-1:0] irq_pending = '0, irq_enable = '0;
    logic [31:0] csr_rdata, redirect_pc, rdata_nc, redirect_pc_nc;
    logic redirect_valid, redirect_valid_nc;

    int vectors = 0, fails = 0;

    // bench model of the trap state
    logic m_ie = 0, m_pie = 0;
    logic [31:0] m_tvec = 0, m_epc = 0, m_cause = 0, m_tval = 0, m_fault = 0;

    logic [11:0] addrs [10] = '{12'h300, 12'h301, 12'h305, 12'h341, 12'h342,
                               12'h343, 12'hF11, 12'hF12, 12'hF13, 12'h7C0};

    always #10 clk = ~clk;

    mtrap_unit #(.IRQ_N(IRQ_N), .ISA_WORD(ISA_C)) u_dut (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_insn(trap_insn),
        .irq_pending(irq_pending), .irq_enable(irq_enable), .mret_valid(mret_valid),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .csr_wen(csr_wen),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

    mtrap_unit #(.IRQ_N(IRQ_N), .ISA_WORD(ISA_NC)) u_dut_nc (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_insn(trap_insn),
        .irq_pending(irq_pending), .irq_enable(irq_enable), .mret_valid(mret_valid),
        .fault_valid(fault_valid), .fault_addr(fault_addr), .csr_wen(csr_wen),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata_nc),
        .redirect_valid(redirect_valid_nc), .redirect_pc(redirect_pc_nc));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h300: return (32'(m_ie) << 3) | (32'(m_pie) << 7);
            12'h301: return ISA_C;
            12'h305: return m_tvec & ~32'd2;
            12'h341: return m_epc;
            12'h342: return m_cause;
            12'h343: return m_tval;
            12'hF11: return 32'h669;
            12'hF12: return 32'h8000_0003;
            12'hF13: return 32'd1;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h305: return "R3";
            12'h341, 12'h342, 12'h300: return "R5";
            12'h343: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic idle();
        trap_valid = 0; trap_irq = 0; mret_valid = 0; fault_valid = 0; csr_wen = 0;
        irq_pending = '0; irq_enable = '0; csr_addr = '0;
    endtask

    // inputs are driven after a falling edge; check redirect, update model, advance
    task automatic go();
        logic take_trap, take_ret;
        logic [31:0] exp_pc;
        #1;
        take_trap = trap_valid && (!trap_irq || (m_ie && |(irq_pending & irq_enable)));
        take_ret  = !take_trap && mret_valid;
        chk(trap_irq ? "R9 redirect_valid" : "R10 redirect_valid",
            32'(redirect_valid), 32'(take_trap || take_ret));
        if (take_trap) begin
            exp_pc = (m_tvec & ~32'd3) + ((m_tvec[0] && trap_irq) ? 32'(trap_cause) * 4 : 32'd0);
            chk("R4 trap target", redirect_pc, exp_pc);
            m_epc   = trap_pc;
            m_cause = {trap_irq, 26'd0, trap_cause};
            if (trap_irq) m_tval = 0;
            else if (trap_cause == 5'd2)
                m_tval = (trap_insn[1:0] == 2'b11) ? trap_insn : {16'd0, trap_insn[15:0]};
            else m_tval = m_fault;
            m_fault = 0;
            m_pie = m_ie; m_ie = 0;
        end else begin
            if (take_ret) begin
                chk("R8 return pc compressed", redirect_pc, m_epc & ~32'd1);
                chk("R8 return pc no-compressed", redirect_pc_nc, m_epc & ~32'd3);
                m_ie = m_pie; m_pie = 1;
            end else if (csr_wen) begin
                case (csr_addr)
                    12'h300: begin m_ie = csr_wdata[3]; m_pie = csr_wdata[7]; end
                    12'h305: m_tvec  = csr_wdata;
                    12'h341: m_epc   = csr_wdata;
                    12'h342: m_cause = csr_wdata;
                    12'h343: m_tval  = csr_wdata;
                    default: ;
                endcase
            end
            if (fault_valid) m_fault = fault_addr;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic readall(input string forced);
        foreach (addrs[i]) begin
            csr_addr = addrs[i];
            #0.5;
            chk(forced != "" ? forced : req_of(addrs[i]), csr_rdata, exp_read(addrs[i]));
        end
        csr_addr = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        csr_wen = 1; csr_addr = a; csr_wdata = d; go();
    endtask

    task automatic trap(input logic irq, input logic [4:0] c, input logic [31:0] pc,
                        input logic [31:0] insn);
        trap_valid = 1; trap_irq = irq; trap_cause = c; trap_pc = pc; trap_insn = insn;
        irq_pending = 16'h0001; irq_enable = 16'h0001; go();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        readall("R1");
        // R2 identity words ignore writes
        wr(12'h301, 32'hFFFF_FFFF); wr(12'hF11, 32'h0); wr(12'hF12, 32'h1); wr(12'hF13, 32'h5);
        readall("");
        // R3 bit 1 of mtvec hidden, vectored mode
        wr(12'h305, 32'h0000_1007);
        wr(12'h300, 32'h0000_0088);
        readall("");
        // R4 vectored interrupt, cause 7
        trap(1, 5'd7, 32'h0000_2000, 32'h0);
        readall("");
        // R9 interrupt refused while MIE is 0
        trap(1, 5'd3, 32'h0000_3000, 32'h0);
        readall("R9");
        // R9 MIE set but nothing pending-and-enabled
        wr(12'h300, 32'h8);
        trap_valid = 1; trap_irq = 1; trap_cause = 5'd11; irq_pending = 16'h0100; irq_enable = 16'h0010; go();
        readall("R9");
        // R7 fault captured, used, then cleared
        fault_valid = 1; fault_addr = 32'hDEAD_0000; go();
        trap(0, 5'd5, 32'h0000_4000, 32'h0);
        readall("R7");
        trap(0, 5'd7, 32'h0000_4004, 32'h0);
        readall("R7");
        // R7 strobe in the trap cycle is lost
        fault_valid = 1; fault_addr = 32'h1111_2222; trap(0, 5'd4, 32'h44, 32'h0);
        trap(0, 5'd6, 32'h48, 32'h0);
        readall("R7");
        // R6 illegal instruction, compressed and full
        trap(0, 5'd2, 32'h0000_5000, 32'hABCD_0001);
        readall("R6");
        trap(0, 5'd2, 32'h0000_5004, 32'h1234_5673);
        readall("R6");
        // R8 odd mepc stored unmasked, masked on return
        wr(12'h341, 32'h0000_0103);
        readall("R8");
        mret_valid = 1; go();
        readall("R8");
        // R10 trap and return together, write dropped
        mret_valid = 1; csr_wen = 1; csr_addr = 12'h305; csr_wdata = 32'h0000_0900;
        trap(0, 5'd1, 32'h0000_6000, 32'h0);
        readall("R10");
        csr_wen = 1; csr_addr = 12'h343; csr_wdata = 32'h5555_5555; mret_valid = 1; go();
        readall("R10");

        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 8);
            case (r)
                0: begin
                    csr_wen = 1; csr_addr = addrs[$urandom % 10]; csr_wdata = $urandom;
                end
                1: begin
                    trap_valid = 1; trap_irq = 0; trap_cause = 5'($urandom);
                    trap_pc = $urandom; trap_insn = $urandom;
                end
                2: begin
                    trap_valid = 1; trap_irq = 0; trap_cause = 5'd2;
                    trap_pc = $urandom; trap_insn = $urandom;
                end
                3: begin
                    trap_valid = 1; trap_irq = 1; trap_cause = 5'($urandom);
                    trap_pc = $urandom; irq_pending = 16'($urandom); irq_enable = 16'($urandom);
                end
                4: mret_valid = 1;
                5: begin fault_valid = 1; fault_addr = $urandom; end
                6: begin
                    trap_valid = 1'($urandom); trap_irq = 1'($urandom); trap_cause = 5'($urandom);
                    trap_pc = $urandom; trap_insn = $urandom; mret_valid = 1'($urandom);
                    irq_pending = 16'($urandom); irq_enable = 16'($urandom);
                    fault_valid = 1'($urandom); fault_addr = $urandom;
                    csr_wen = 1'($urandom); csr_addr = addrs[$urandom % 10]; csr_wdata = $urandom;
                end
                default: wr(12'h300, 32'($urandom) | 32'h8);
            endcase
            if (r != 7) go();
            readall("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule